// File: doc/BRIEF.md
# Dual-Queue Packet Buffer with Request-Driven Reads

This block buffers packet words between system logic and a serial link engine. It holds two independent queues: a regular queue and a priority queue. Each queue has its own write strobe, its own read request and its own output registers. A word is 8 bytes wide by default (four lanes of two bytes each). Each word carries a start-of-packet flag, an end-of-packet flag and an empty-byte count. The empty-byte count says how many trailing bytes of a packet's final word hold no data.

The producer presents a word together with a write strobe, and the buffer captures it on that same rising edge, with no wait state. The consumer raises a read request. On the edge that samples the request, the buffer loads the oldest stored word into its output registers and raises the valid flag, and the consumer captures the word on the following edge. When no word is stored, valid stays low. The block also sanitises the empty-byte count, zeroes the bytes it marks as unused, and keeps two sticky error flags per queue: one for a write into a full queue, and one for a malformed empty count.

Top module: `dual_pkt_buffer`

## Requirements
- R1: A word presented with the write strobe high at a rising edge is captured at that edge, and the words of one queue are returned in the order they were written.
- R2: If a read request is high at a rising edge and the queue holds a word at that edge, then after that edge the valid flag is 1 and the output fields carry the oldest stored word.
- R3: If a read request is high at an edge and the queue holds no word at that edge, valid is 0 after that edge. This includes a word being written at the same edge.
- R4: If the read request is low at an edge, valid is 0 after that edge, and the data, start, end and empty-count outputs keep their previous values.
- R5: On a word whose end flag is 1, the empty count m (0 to 7) is returned unchanged, and bytes 0 to m-1 are returned as zero. Byte k is data bits [8k+7:8k], and the first byte in transmission order is bits [63:56].
- R6: A write whose empty count is nonzero while its end flag is 0 is stored with an empty count of 0, and it sets that queue's sticky bad-count flag after the same edge.
- R7: A write at an edge where the queue already holds DEPTH words is dropped, even if a read happens at that same edge. It sets that queue's sticky overflow flag after that edge.
- R8: Activity on one queue never changes the outputs or the contents of the other queue.
- R9: While rst_n is low, both queues are empty and every valid flag, error flag and output field reads 0. This takes effect at once, without waiting for a clock edge.
- R10: A queue accepts DEPTH consecutive writes (16 by default) without loss, and returns exactly DEPTH words when it is then drained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| norm_wr_en | input | 1 | Regular queue write strobe |
| norm_wr_data | input | 64 | Regular queue write data, first byte in bits [63:56] |
| norm_wr_sop | input | 1 | Regular queue write start-of-packet |
| norm_wr_eop | input | 1 | Regular queue write end-of-packet |
| norm_wr_mty | input | 3 | Regular queue write empty-byte count |
| norm_rd_en | input | 1 | Regular queue read request |
| norm_rd_valid | output | 1 | Regular queue output word valid |
| norm_rd_data | output | 64 | Regular queue output data |
| norm_rd_sop | output | 1 | Regular queue output start-of-packet |
| norm_rd_eop | output | 1 | Regular queue output end-of-packet |
| norm_rd_mty | output | 3 | Regular queue output empty-byte count |
| norm_overflow | output | 1 | Regular queue sticky write-when-full flag |
| norm_bad_mty | output | 1 | Regular queue sticky malformed empty-count flag |
| prio_wr_en | input | 1 | Priority queue write strobe |
| prio_wr_data | input | 64 | Priority queue write data |
| prio_wr_sop | input | 1 | Priority queue write start-of-packet |
| prio_wr_eop | input | 1 | Priority queue write end-of-packet |
| prio_wr_mty | input | 3 | Priority queue write empty-byte count |
| prio_rd_en | input | 1 | Priority queue read request |
| prio_rd_valid | output | 1 | Priority queue output word valid |
| prio_rd_data | output | 64 | Priority queue output data |
| prio_rd_sop | output | 1 | Priority queue output start-of-packet |
| prio_rd_eop | output | 1 | Priority queue output end-of-packet |
| prio_rd_mty | output | 3 | Priority queue output empty-byte count |
| prio_overflow | output | 1 | Priority queue sticky write-when-full flag |
| prio_bad_mty | output | 1 | Priority queue sticky malformed empty-count flag |

## Verification
Every registered result is due right after the rising edge that samples the stimulus causing it: the valid flag, the output word and both error flags all follow the edge that samples the write strobe or read request. The bench drives inputs at a falling edge and advances its reference model by exactly one step for the rising edge that follows. It then compares the outputs at the next falling edge, so every comparison lands one half period after the edge that is due to produce the result. Reset is the only result with no edge in between, and the bench checks it a short delay after pulling rst_n low.

// File: rtl/pktbuf_pkg.sv
package pktbuf_pkg;

  localparam int unsigned NUM_CH = 2;

  typedef enum logic [0:0] {
    CH_REGULAR  = 1'b0,
    CH_PRIORITY = 1'b1
  } chan_e;

  // Two bytes per lane.
  function automatic int unsigned word_bytes(input int unsigned lanes);
    return 2 * lanes;
  endfunction

  // Width needed for an empty count of 0 .. nbytes-1.
  function automatic int unsigned count_bits(input int unsigned nbytes);
    return (nbytes > 1) ? $clog2(nbytes) : 1;
  endfunction

endpackage

// File: rtl/pktbuf_shaper.sv
// Sanitises the empty count and zeroes unused trailing bytes before storage.
module pktbuf_shaper #(
  parameter int unsigned BYTES = 8,
  parameter int unsigned MTY_W = 3,
  localparam int unsigned DATA_W = 8 * BYTES,
  localparam int unsigned ENT_W  = DATA_W + 2 + MTY_W
) (
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_sop,
  input  logic              in_eop,
  input  logic [MTY_W-1:0]  in_mty,
  output logic [ENT_W-1:0]  out_entry,
  output logic              bad_mty
);

  logic [MTY_W-1:0]  mty_eff;
  logic [DATA_W-1:0] data_masked;

  always_comb begin
    bad_mty = (in_mty != '0) && !in_eop;
    mty_eff = in_eop ? in_mty : '0;
  end

  // Byte b sits at bits [8b+7:8b]; the lowest mty_eff bytes are unused.
  for (genvar b = 0; b < BYTES; b++) begin : g_byte
    localparam logic [MTY_W-1:0] BIDX = MTY_W'(b);
    assign data_masked[8*b +: 8] = (BIDX < mty_eff) ? 8'h00 : in_data[8*b +: 8];
  end

  assign out_entry = {in_sop, in_eop, mty_eff, data_masked};

endmodule

// File: rtl/pktbuf_store.sv
// Circular word storage with occupancy count.
module pktbuf_store #(
  parameter int unsigned ENT_W = 69,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_req,
  input  logic [ENT_W-1:0] push_entry,
  input  logic             pop_req,
  output logic [ENT_W-1:0] head_entry,
  output logic             has_word,
  output logic             is_full
);

  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d;
  logic [PTR_W-1:0] rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             do_push, do_pop;
  logic [ENT_W-1:0] mem_q [DEPTH];

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    has_word = (cnt_q != '0);
    is_full  = (cnt_q == FULL_CNT);
    do_push  = push_req && !is_full;
    do_pop   = pop_req && has_word;
    wr_ptr_d = do_push ? bump(wr_ptr_q) : wr_ptr_q;
    rd_ptr_d = do_pop  ? bump(rd_ptr_q) : rd_ptr_q;
    unique case ({do_push, do_pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) begin
      mem_q[wr_ptr_q] <= push_entry;
    end
  end

  assign head_entry = mem_q[rd_ptr_q];

endmodule

// File: rtl/pktbuf_rdstage.sv
// Output registers: one word per granted request, held otherwise.
module pktbuf_rdstage #(
  parameter int unsigned ENT_W = 69
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_req,
  input  logic             has_word,
  input  logic [ENT_W-1:0] head_entry,
  output logic             pop_req,
  output logic             out_valid,
  output logic [ENT_W-1:0] out_entry
);

  logic             take;
  logic             valid_d, valid_q;
  logic [ENT_W-1:0] ent_d, ent_q;

  always_comb begin
    take    = rd_req && has_word;
    pop_req = take;
    valid_d = take;
    ent_d   = head_entry;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      ent_q   <= '0;
    end else begin
      valid_q <= valid_d;
      if (take) begin
        ent_q <= ent_d;
      end
    end
  end

  assign out_valid = valid_q;
  assign out_entry = ent_q;

endmodule

// File: rtl/pktbuf_channel.sv
// One queue: shaper, storage, output stage and sticky error flags.
module pktbuf_channel #(
  parameter int unsigned BYTES = 8,
  parameter int unsigned MTY_W = 3,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned DATA_W = 8 * BYTES,
  localparam int unsigned ENT_W  = DATA_W + 2 + MTY_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_sop,
  input  logic              wr_eop,
  input  logic [MTY_W-1:0]  wr_mty,
  input  logic              rd_en,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_sop,
  output logic              rd_eop,
  output logic [MTY_W-1:0]  rd_mty,
  output logic              overflow,
  output logic              bad_mty
);

  logic [ENT_W-1:0] shaped_entry;
  logic             shaped_bad;
  logic [ENT_W-1:0] head_entry;
  logic [ENT_W-1:0] out_entry;
  logic             has_word, is_full, pop_req;
  logic             ovf_d, ovf_q, bad_d, bad_q;

  pktbuf_shaper #(.BYTES(BYTES), .MTY_W(MTY_W)) u_shaper (
    .in_data   (wr_data),
    .in_sop    (wr_sop),
    .in_eop    (wr_eop),
    .in_mty    (wr_mty),
    .out_entry (shaped_entry),
    .bad_mty   (shaped_bad)
  );

  pktbuf_store #(.ENT_W(ENT_W), .DEPTH(DEPTH)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_req   (wr_en),
    .push_entry (shaped_entry),
    .pop_req    (pop_req),
    .head_entry (head_entry),
    .has_word   (has_word),
    .is_full    (is_full)
  );

  pktbuf_rdstage #(.ENT_W(ENT_W)) u_rdstage (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_req     (rd_en),
    .has_word   (has_word),
    .head_entry (head_entry),
    .pop_req    (pop_req),
    .out_valid  (rd_valid),
    .out_entry  (out_entry)
  );

  always_comb begin
    ovf_d = ovf_q || (wr_en && is_full);
    bad_d = bad_q || (wr_en && shaped_bad);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
      bad_q <= 1'b0;
    end else begin
      ovf_q <= ovf_d;
      bad_q <= bad_d;
    end
  end

  assign {rd_sop, rd_eop, rd_mty, rd_data} = out_entry;
  assign overflow = ovf_q;
  assign bad_mty  = bad_q;

endmodule

// File: rtl/dual_pkt_buffer.sv
module dual_pkt_buffer
  import pktbuf_pkg::*;
#(
  parameter int unsigned LANES = 4,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned BYTES  = word_bytes(LANES),
  localparam int unsigned DATA_W = 8 * BYTES,
  localparam int unsigned MTY_W  = count_bits(BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              norm_wr_en,
  input  logic [DATA_W-1:0] norm_wr_data,
  input  logic              norm_wr_sop,
  input  logic              norm_wr_eop,
  input  logic [MTY_W-1:0]  norm_wr_mty,
  input  logic              norm_rd_en,
  output logic              norm_rd_valid,
  output logic [DATA_W-1:0] norm_rd_data,
  output logic              norm_rd_sop,
  output logic              norm_rd_eop,
  output logic [MTY_W-1:0]  norm_rd_mty,
  output logic              norm_overflow,
  output logic              norm_bad_mty,
  input  logic              prio_wr_en,
  input  logic [DATA_W-1:0] prio_wr_data,
  input  logic              prio_wr_sop,
  input  logic              prio_wr_eop,
  input  logic [MTY_W-1:0]  prio_wr_mty,
  input  logic              prio_rd_en,
  output logic              prio_rd_valid,
  output logic [DATA_W-1:0] prio_rd_data,
  output logic              prio_rd_sop,
  output logic              prio_rd_eop,
  output logic [MTY_W-1:0]  prio_rd_mty,
  output logic              prio_overflow,
  output logic              prio_bad_mty
);

  localparam int NRM = int'(CH_REGULAR);
  localparam int PRI = int'(CH_PRIORITY);

  logic [NUM_CH-1:0]             wr_en_v, wr_sop_v, wr_eop_v, rd_en_v;
  logic [NUM_CH-1:0]             rd_valid_v, rd_sop_v, rd_eop_v, ovf_v, bad_v;
  logic [NUM_CH-1:0][DATA_W-1:0] wr_data_v, rd_data_v;
  logic [NUM_CH-1:0][MTY_W-1:0]  wr_mty_v, rd_mty_v;

  assign wr_en_v[NRM]   = norm_wr_en;
  assign wr_data_v[NRM] = norm_wr_data;
  assign wr_sop_v[NRM]  = norm_wr_sop;
  assign wr_eop_v[NRM]  = norm_wr_eop;
  assign wr_mty_v[NRM]  = norm_wr_mty;
  assign rd_en_v[NRM]   = norm_rd_en;
  assign wr_en_v[PRI]   = prio_wr_en;
  assign wr_data_v[PRI] = prio_wr_data;
  assign wr_sop_v[PRI]  = prio_wr_sop;
  assign wr_eop_v[PRI]  = prio_wr_eop;
  assign wr_mty_v[PRI]  = prio_wr_mty;
  assign rd_en_v[PRI]   = prio_rd_en;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pktbuf_channel #(.BYTES(BYTES), .MTY_W(MTY_W), .DEPTH(DEPTH)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en_v[c]),
      .wr_data  (wr_data_v[c]),
      .wr_sop   (wr_sop_v[c]),
      .wr_eop   (wr_eop_v[c]),
      .wr_mty   (wr_mty_v[c]),
      .rd_en    (rd_en_v[c]),
      .rd_valid (rd_valid_v[c]),
      .rd_data  (rd_data_v[c]),
      .rd_sop   (rd_sop_v[c]),
      .rd_eop   (rd_eop_v[c]),
      .rd_mty   (rd_mty_v[c]),
      .overflow (ovf_v[c]),
      .bad_mty  (bad_v[c])
    );
  end

  assign norm_rd_valid = rd_valid_v[NRM];
  assign norm_rd_data  = rd_data_v[NRM];
  assign norm_rd_sop   = rd_sop_v[NRM];
  assign norm_rd_eop   = rd_eop_v[NRM];
  assign norm_rd_mty   = rd_mty_v[NRM];
  assign norm_overflow = ovf_v[NRM];
  assign norm_bad_mty  = bad_v[NRM];
  assign prio_rd_valid = rd_valid_v[PRI];
  assign prio_rd_data  = rd_data_v[PRI];
  assign prio_rd_sop   = rd_sop_v[PRI];
  assign prio_rd_eop   = rd_eop_v[PRI];
  assign prio_rd_mty   = rd_mty_v[PRI];
  assign prio_overflow = ovf_v[PRI];
  assign prio_bad_mty  = bad_v[PRI];

endmodule

// File: rtl/pktbuf_checker.sv
module pktbuf_checker
  import pktbuf_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned MTY_W  = 3
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic [NUM_CH-1:0]               wr_en_v,
  input logic [NUM_CH-1:0]               rd_en_v,
  input logic [NUM_CH-1:0]               rd_valid_v,
  input logic [NUM_CH-1:0][DATA_W-1:0]   rd_data_v,
  input logic [NUM_CH-1:0]               rd_eop_v,
  input logic [NUM_CH-1:0][MTY_W-1:0]    rd_mty_v,
  input logic [NUM_CH-1:0]               ovf_v,
  input logic [NUM_CH-1:0]               bad_v
);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    // R2: a valid word only follows an edge that sampled a read request
    p_valid_after_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid_v[c] |-> $past(rd_en_v[c]));

    // R4: outputs hold whenever no word was delivered
    p_hold_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_valid_v[c] |-> ($stable(rd_data_v[c]) && $stable(rd_mty_v[c]) && $stable(rd_eop_v[c])));

    // R6: empty count is zero on every delivered word without end flag
    p_mty_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid_v[c] && !rd_eop_v[c]) |-> (rd_mty_v[c] == '0));

    // R6: bad-count flag is sticky
    p_bad_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(bad_v[c]) |-> bad_v[c]);

    // R7: overflow flag is sticky
    p_overflow_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ovf_v[c]) |-> ovf_v[c]);

    // R7: overflow only rises after a write strobe
    p_overflow_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_v[c]) |-> $past(wr_en_v[c]));
  end

endmodule

bind dual_pkt_buffer pktbuf_checker #(.DATA_W(DATA_W), .MTY_W(MTY_W)) u_pktbuf_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en_v    (wr_en_v),
  .rd_en_v    (rd_en_v),
  .rd_valid_v (rd_valid_v),
  .rd_data_v  (rd_data_v),
  .rd_eop_v   (rd_eop_v),
  .rd_mty_v   (rd_mty_v),
  .ovf_v      (ovf_v),
  .bad_v      (bad_v)
);

// File: tb/dual_pkt_buffer_bench.sv
module dual_pkt_buffer_bench;

  localparam int CLK_PERIOD = 10;
  localparam int LANES  = 4;
  localparam int DEPTH  = 16;
  localparam int BYTES  = 2 * LANES;
  localparam int DATA_W = 8 * BYTES;
  localparam int MTY_W  = 3;
  localparam int ENT_W  = DATA_W + 2 + MTY_W;
  localparam int WATCHDOG = 100000;

  logic clk;
  logic rst_n;

  logic              wr_en   [2];
  logic [DATA_W-1:0] wr_data [2];
  logic              wr_sop  [2];
  logic              wr_eop  [2];
  logic [MTY_W-1:0]  wr_mty  [2];
  logic              rd_en   [2];
  logic              rd_valid[2];
  logic [DATA_W-1:0] rd_data [2];
  logic              rd_sop  [2];
  logic              rd_eop  [2];
  logic [MTY_W-1:0]  rd_mty  [2];
  logic              ovf     [2];
  logic              bad     [2];

  dual_pkt_buffer #(.LANES(LANES), .DEPTH(DEPTH)) u_dual_pkt_buffer (
    .clk(clk), .rst_n(rst_n),
    .norm_wr_en(wr_en[0]), .norm_wr_data(wr_data[0]), .norm_wr_sop(wr_sop[0]),
    .norm_wr_eop(wr_eop[0]), .norm_wr_mty(wr_mty[0]), .norm_rd_en(rd_en[0]),
    .norm_rd_valid(rd_valid[0]), .norm_rd_data(rd_data[0]), .norm_rd_sop(rd_sop[0]),
    .norm_rd_eop(rd_eop[0]), .norm_rd_mty(rd_mty[0]), .norm_overflow(ovf[0]),
    .norm_bad_mty(bad[0]),
    .prio_wr_en(wr_en[1]), .prio_wr_data(wr_data[1]), .prio_wr_sop(wr_sop[1]),
    .prio_wr_eop(wr_eop[1]), .prio_wr_mty(wr_mty[1]), .prio_rd_en(rd_en[1]),
    .prio_rd_valid(rd_valid[1]), .prio_rd_data(rd_data[1]), .prio_rd_sop(rd_sop[1]),
    .prio_rd_eop(rd_eop[1]), .prio_rd_mty(rd_mty[1]), .prio_overflow(ovf[1]),
    .prio_bad_mty(bad[1])
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  // Reference model: circular buffer per queue plus expected outputs.
  logic [ENT_W-1:0] mbuf [2][DEPTH];
  int               mhead [2];
  int               mcnt  [2];
  logic             exp_valid [2];
  logic [ENT_W-1:0] exp_ent   [2];
  logic             exp_ovf   [2];
  logic             exp_bad   [2];
  logic             saw_rd    [2];

  // R5/R6: expected stored form of a written word.
  function automatic logic [ENT_W-1:0] shape(input logic [DATA_W-1:0] d, input logic s,
                                             input logic e, input logic [MTY_W-1:0] m);
    logic [MTY_W-1:0]  me;
    logic [DATA_W-1:0] dm;
    me = e ? m : '0;
    dm = d;
    for (int b = 0; b < BYTES; b++) begin
      if (b < int'(me)) dm[8*b +: 8] = 8'h00;
    end
    return {s, e, me, dm};
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [ENT_W-1:0] act, input logic [ENT_W-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int c = 0; c < 2; c++) begin
      mhead[c] = 0; mcnt[c] = 0;
      exp_valid[c] = 0; exp_ent[c] = '0; exp_ovf[c] = 0; exp_bad[c] = 0; saw_rd[c] = 0;
    end
  endtask

  task automatic model_step();
    for (int c = 0; c < 2; c++) begin
      bit full;
      full = (mcnt[c] == DEPTH);
      saw_rd[c] = rd_en[c];
      if (rd_en[c] && mcnt[c] != 0) begin
        exp_valid[c] = 1;
        exp_ent[c]   = mbuf[c][mhead[c]];
        mhead[c]     = (mhead[c] + 1) % DEPTH;
        mcnt[c]--;
      end else begin
        exp_valid[c] = 0;
      end
      if (wr_en[c]) begin
        if (wr_mty[c] != '0 && !wr_eop[c]) exp_bad[c] = 1;
        if (full) exp_ovf[c] = 1;
        else begin
          mbuf[c][(mhead[c] + mcnt[c]) % DEPTH] = shape(wr_data[c], wr_sop[c], wr_eop[c], wr_mty[c]);
          mcnt[c]++;
        end
      end
    end
  endtask

  task automatic compare_outputs();
    for (int c = 0; c < 2; c++) begin
      string vt;
      logic [ENT_W-1:0] act;
      vt  = exp_valid[c] ? "R2" : (saw_rd[c] ? "R3" : "R4");
      act = {rd_sop[c], rd_eop[c], rd_mty[c], rd_data[c]};
      check(rd_valid[c] == exp_valid[c], vt, $sformatf("ch%0d valid", c),
            ENT_W'(rd_valid[c]), ENT_W'(exp_valid[c]));
      check(act == exp_ent[c], exp_valid[c] ? "R1" : "R4", $sformatf("ch%0d word", c),
            act, exp_ent[c]);
      check(ovf[c] == exp_ovf[c], "R7", $sformatf("ch%0d overflow", c),
            ENT_W'(ovf[c]), ENT_W'(exp_ovf[c]));
      check(bad[c] == exp_bad[c], "R6", $sformatf("ch%0d bad count", c),
            ENT_W'(bad[c]), ENT_W'(exp_bad[c]));
    end
  endtask

  task automatic run_cycle();
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare_outputs();
  endtask

  task automatic idle_inputs();
    for (int c = 0; c < 2; c++) begin
      wr_en[c] = 0; wr_data[c] = '0; wr_sop[c] = 0; wr_eop[c] = 0; wr_mty[c] = '0; rd_en[c] = 0;
    end
  endtask

  task automatic set_write(input int c, input logic [DATA_W-1:0] d, input logic s,
                           input logic e, input logic [MTY_W-1:0] m);
    wr_en[c] = 1; wr_data[c] = d; wr_sop[c] = s; wr_eop[c] = e; wr_mty[c] = m;
  endtask

  // R9: every output of both queues reads zero.
  task automatic check_reset_state(input string what);
    for (int c = 0; c < 2; c++) begin
      logic [ENT_W-1:0] act;
      act = {rd_sop[c], rd_eop[c], rd_mty[c], rd_data[c]};
      check(!rd_valid[c] && !ovf[c] && !bad[c] && act == '0, "R9",
            $sformatf("%s ch%0d", what, c),
            {rd_valid[c], ovf[c], bad[c], act[ENT_W-4:0]}, '0);
    end
  endtask

  // Watchdog: an expired run counts as a failed check.
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG && !done) begin
      done = 1;
      n_checks++;
      n_fail++;
      $display("FAIL R1 watchdog: actual cycles=%0d expected below %0d", cyc, WATCHDOG);
      $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    int nvalid;
    seed = $urandom(32'h5EED_0042);
    idle_inputs();
    model_reset();
    rst_n = 1'b0;
    #(CLK_PERIOD * 3);
    @(negedge clk);
    check_reset_state("initial reset");
    rst_n = 1'b1;

    // R3: read at the edge that writes the first word gets nothing.
    set_write(0, 64'h0102030405060708, 1, 0, 0);
    rd_en[0] = 1;
    run_cycle();
    idle_inputs();
    rd_en[0] = 1;                          // R2: now the word is delivered
    run_cycle();
    idle_inputs();
    run_cycle();                           // R4: outputs hold, valid drops

    // R10 / R7: fill the regular queue, then a write while full.
    for (int i = 0; i < DEPTH; i++) begin
      idle_inputs();
      set_write(0, {32'hA5A5_0000 + i, 32'h1234_0000 + i}, i == 0, i == DEPTH - 1, 0);
      run_cycle();
    end
    idle_inputs();
    set_write(0, 64'hDEAD_BEEF_DEAD_BEEF, 0, 0, 0);
    rd_en[0] = 1;                          // R7: read at same edge does not make room
    run_cycle();
    check(ovf[0] == 1'b1, "R7", "overflow after write into full queue",
          ENT_W'(ovf[0]), ENT_W'(1));
    nvalid = 1;                            // one word left via the read above
    if (!rd_valid[0]) nvalid = 0;
    idle_inputs();
    for (int i = 0; i < DEPTH + 2; i++) begin
      rd_en[0] = 1;
      run_cycle();
      if (rd_valid[0]) nvalid++;
    end
    check(nvalid == DEPTH, "R10", "words drained after fill",
          ENT_W'(nvalid), ENT_W'(DEPTH));

    // R5: trailing-byte masking on end words.
    idle_inputs();
    set_write(1, 64'hFFFF_FFFF_FFFF_FFFF, 1, 1, 3'd7);
    run_cycle();
    idle_inputs();
    set_write(1, 64'h1122_3344_5566_7788, 0, 1, 3'd3);
    rd_en[1] = 1;
    run_cycle();
    check(rd_data[1] == 64'hFF00_0000_0000_0000 && rd_mty[1] == 3'd7, "R5",
          "mty 7 keeps only byte 7", {rd_mty[1], rd_data[1]}, {3'd7, 64'hFF00_0000_0000_0000});
    idle_inputs();
    set_write(1, 64'h99AA_BBCC_DDEE_F011, 1, 1, 3'd0);
    rd_en[1] = 1;
    run_cycle();
    idle_inputs();
    // R6: nonzero count without end flag.
    set_write(1, 64'h0F0F_0F0F_0F0F_0F0F, 0, 0, 3'd5);
    rd_en[1] = 1;
    run_cycle();
    idle_inputs();
    rd_en[1] = 1;
    run_cycle();
    check(rd_valid[1] && rd_mty[1] == 3'd0 && rd_data[1] == 64'h0F0F_0F0F_0F0F_0F0F, "R6",
          "count cleared on non-end word", {rd_mty[1], rd_data[1]}, {3'd0, 64'h0F0F_0F0F_0F0F_0F0F});

    // R8: regular-queue traffic leaves the priority queue untouched.
    idle_inputs();
    for (int i = 0; i < 3; i++) begin
      set_write(0, 64'hC0DE_0000_0000_0000 + i, 0, 0, 0);
      rd_en[1] = 1;
      run_cycle();
      check(!rd_valid[1] && !bad[1] == !exp_bad[1], "R8", "priority idle under regular writes",
            ENT_W'(rd_valid[1]), ENT_W'(0));
    end
    idle_inputs();

    // R9: asynchronous reset in mid-run.
    set_write(0, 64'h5555_AAAA_5555_AAAA, 1, 1, 1);
    rd_en[0] = 1;
    rd_en[1] = 1;
    run_cycle();
    idle_inputs();
    #(CLK_PERIOD / 4);
    rst_n = 1'b0;
    #1;
    check_reset_state("mid-run reset");
    model_reset();
    @(negedge clk);
    rst_n = 1'b1;
    rd_en[0] = 1;
    run_cycle();                           // R9: queue really emptied

    // Random traffic on both queues (R1..R8).
    for (int seg = 0; seg < 4; seg++) begin
      int pw, pr;
      pw = (seg == 0) ? 70 : (seg == 1) ? 30 : (seg == 2) ? 50 : 90;
      pr = (seg == 0) ? 30 : (seg == 1) ? 70 : (seg == 2) ? 50 : 90;
      for (int n = 0; n < 800; n++) begin
        for (int c = 0; c < 2; c++) begin
          logic e;
          logic [MTY_W-1:0] m;
          e = ($urandom % 4) == 0;
          if (e) m = MTY_W'($urandom % 8);
          else   m = (($urandom % 25) == 0) ? MTY_W'($urandom % 8) : '0;
          wr_en[c]   = ($urandom % 100) < pw;
          wr_data[c] = {$urandom, $urandom};
          wr_sop[c]  = ($urandom % 4) == 0;
          wr_eop[c]  = e;
          wr_mty[c]  = m;
          rd_en[c]   = ($urandom % 100) < pr;
        end
        run_cycle();
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
    $finish;
  end

endmodule